// File: doc/BRIEF.md
# Switchable ISA-Variant Context Controller

This block keeps the writable vendor/architecture identifier of one hart and uses it to choose which of several instruction-encoding variants the hart runs. It drives a set of decode-engine enable wires from the stored identifier. Exactly one of these wires is high at any time. It also holds one bank of trap-vector registers for each variant, with machine, supervisor and user entries in each bank. When a trap is requested, it returns the vector from the bank of the variant that is active.

A write of a legal identifier does not take effect at once. It passes through a short switch sequence. The state machine has two states, `SW_RUN` and `SW_COMMIT`:

- **Start switch** (`SW_RUN` to `SW_COMMIT`): taken on a legal identifier write.
- **Commit switch** (`SW_COMMIT` to `SW_RUN`): taken unconditionally one cycle later.
- **Idle hold** (`SW_RUN` to `SW_RUN`): taken on no write or an illegal write.

While in `SW_COMMIT`, the pipeline is stalled. The new variant index and the trap-vector bank select change together at the commit edge. A trap sampled before that edge therefore always uses the old variant's handlers. Vector contents are never touched by a switch.

Top module: `isa_variant_ctl`

## Requirements
- R1: After reset, variant 0 is active, `dec_en` is 4'b0001, `stall` is low, `trap_vec_valid` is low, and every stored trap vector reads as zero.
- R2: The legal identifiers are `{VENDOR_ID, ARCH_BASE+k}` for k = 0..3, with the vendor in bits 31:16 and the architecture in bits 15:0. `id_rd_data` always returns the identifier of the active variant k.
- R3: An identifier write whose vendor half differs from `VENDOR_ID`, or whose architecture half is outside `ARCH_BASE..ARCH_BASE+3`, is ignored: `stall` stays low and `id_rd_data` is unchanged.
- R4: `dec_en` has exactly one bit set at all times, and that bit is bit k of the active variant k.
- R5: A legal write sampled at clock edge E moves the block to `SW_COMMIT`, so `stall` is high for exactly the cycle after E. The new identifier and `dec_en` appear after edge E+1.
- R6: An identifier write sampled while `stall` is high is ignored.
- R7: A vector write stores `vec_wr_data` into the entry chosen by variant `vec_wr_var` and kind `vec_wr_kind`, where kind 0 is machine, 1 is supervisor and 2 is user. Kind code 3 writes nothing.
- R8: A trap request sampled at edge E makes `trap_vec_valid` high after E for one cycle. `trap_vec` then holds the entry of the active variant for `trap_kind`, or zero when `trap_kind` is 3.
- R9: A trap never changes the active identifier.
- R10: A trap sampled on the same edge as a legal identifier write, or while `stall` is high, is serviced with the old variant's vectors.
- R11: Switching variants never alters any stored trap vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_wr_en | input | 1 | Identifier write strobe |
| id_wr_data | input | 32 | Identifier to write, {vendor, architecture} |
| id_rd_data | output | 32 | Identifier of the active variant |
| vec_wr_en | input | 1 | Trap-vector write strobe |
| vec_wr_var | input | 2 | Variant bank to write |
| vec_wr_kind | input | 2 | Vector kind: 0 machine, 1 supervisor, 2 user |
| vec_wr_data | input | 32 | Vector value to store |
| trap_req | input | 1 | Trap request |
| trap_kind | input | 2 | Privilege level of the trap, coded like `vec_wr_kind` |
| trap_vec | output | 32 | Selected trap vector |
| trap_vec_valid | output | 1 | `trap_vec` is valid this cycle |
| dec_en | output | 4 | One-hot decode-engine enables |
| stall | output | 1 | Pipeline stall during a variant switch |

## Verification
The bench targets the atomicity edges of a switch.

- **Trap on the write edge and trap during the stall cycle.** A design that moved the bank select early would return the new variant's handler here.
- **Identifier write during the stall cycle.** A design that accepted it would end on the wrong variant.
- **Illegal identifiers (wrong vendor and out-of-range architecture).** A non-WARL design would stall or change the read value.
- **Vector contents after several switches, and writes with kind code 3.** These catch a bank cleared by a switch, or a stray write to a real entry.

// File: rtl/isa_variant_pkg.sv
package isa_variant_pkg;
    localparam int NKIND = 3;

    typedef enum logic [1:0] {
        VK_MACH = 2'd0,
        VK_SUPV = 2'd1,
        VK_USER = 2'd2,
        VK_NONE = 2'd3
    } vec_kind_e;

    typedef enum logic {
        SW_RUN    = 1'b0,
        SW_COMMIT = 1'b1
    } sw_state_e;
endpackage

// File: rtl/isa_variant_fsm.sv
module isa_variant_fsm
    import isa_variant_pkg::*;
#(
    parameter int              NVAR      = 4,
    parameter int              HALF_W    = 16,
    parameter logic [HALF_W-1:0] VENDOR_ID = 16'h05A1,
    parameter logic [HALF_W-1:0] ARCH_BASE = 16'h0100,
    localparam int             IDX_W     = $clog2(NVAR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                id_wr_en,
    input  logic [2*HALF_W-1:0] id_wr_data,
    output logic [IDX_W-1:0]    active_idx,
    output logic                stall,
    output logic [2*HALF_W-1:0] id_rd_data
);
    sw_state_e          state_q, state_d;
    logic [IDX_W-1:0]   pend_q;
    logic [HALF_W-1:0]  arch_off;
    logic               wr_legal;

    assign arch_off = id_wr_data[HALF_W-1:0] - ARCH_BASE;
    assign wr_legal = (id_wr_data[2*HALF_W-1:HALF_W] == VENDOR_ID)
                   && (arch_off < HALF_W'(NVAR));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_RUN:    if (id_wr_en && wr_legal) state_d = SW_COMMIT;
            SW_COMMIT: state_d = SW_RUN;
            default:   state_d = SW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SW_RUN;
            pend_q     <= '0;
            active_idx <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SW_RUN && id_wr_en && wr_legal)
                pend_q <= arch_off[IDX_W-1:0];
            if (state_q == SW_COMMIT)
                active_idx <= pend_q;
        end
    end

    always_comb begin
        stall = 1'b0;
        unique case (state_q)
            SW_RUN:    stall = 1'b0;
            SW_COMMIT: stall = 1'b1;
            default:   stall = 1'b0;
        endcase
        id_rd_data = {VENDOR_ID, ARCH_BASE + HALF_W'(active_idx)};
    end
endmodule

// File: rtl/isa_vec_bank.sv
module isa_vec_bank
    import isa_variant_pkg::*;
#(
    parameter int  NVAR  = 4,
    parameter int  XLEN  = 32,
    localparam int IDX_W = $clog2(NVAR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_var,
    input  logic [1:0]       wr_kind,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] sel_var,
    input  logic             trap_req,
    input  logic [1:0]       trap_kind,
    output logic [XLEN-1:0]  trap_vec,
    output logic             trap_vec_valid
);
    logic [XLEN-1:0] bank [NVAR][NKIND];
    logic [XLEN-1:0] rd_val;

    always_comb begin
        unique case (vec_kind_e'(trap_kind))
            VK_MACH: rd_val = bank[sel_var][0];
            VK_SUPV: rd_val = bank[sel_var][1];
            VK_USER: rd_val = bank[sel_var][2];
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NVAR; v++)
                for (int k = 0; k < NKIND; k++)
                    bank[v][k] <= '0;
            trap_vec       <= '0;
            trap_vec_valid <= 1'b0;
        end else begin
            if (wr_en && wr_kind != VK_NONE)
                bank[wr_var][wr_kind] <= wr_data;
            trap_vec_valid <= trap_req;
            if (trap_req)
                trap_vec <= rd_val;
        end
    end
endmodule

// File: rtl/isa_dec_onehot.sv
module isa_dec_onehot #(
    parameter int  NVAR  = 4,
    localparam int IDX_W = $clog2(NVAR)
) (
    input  logic [IDX_W-1:0] active_idx,
    output logic [NVAR-1:0]  dec_en
);
    for (genvar g = 0; g < NVAR; g++) begin : g_en
        assign dec_en[g] = (active_idx == IDX_W'(g));
    end
endmodule

// File: rtl/isa_variant_ctl.sv
module isa_variant_ctl #(
    parameter int          NVAR      = 4,
    parameter int          XLEN      = 32,
    parameter logic [15:0] VENDOR_ID = 16'h05A1,
    parameter logic [15:0] ARCH_BASE = 16'h0100,
    localparam int         IDX_W     = $clog2(NVAR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_wr_en,
    input  logic [31:0]      id_wr_data,
    output logic [31:0]      id_rd_data,
    input  logic             vec_wr_en,
    input  logic [IDX_W-1:0] vec_wr_var,
    input  logic [1:0]       vec_wr_kind,
    input  logic [XLEN-1:0]  vec_wr_data,
    input  logic             trap_req,
    input  logic [1:0]       trap_kind,
    output logic [XLEN-1:0]  trap_vec,
    output logic             trap_vec_valid,
    output logic [NVAR-1:0]  dec_en,
    output logic             stall
);
    logic [IDX_W-1:0] active_idx;

    isa_variant_fsm #(
        .NVAR(NVAR), .HALF_W(16), .VENDOR_ID(VENDOR_ID), .ARCH_BASE(ARCH_BASE)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .id_wr_en(id_wr_en), .id_wr_data(id_wr_data),
        .active_idx(active_idx), .stall(stall), .id_rd_data(id_rd_data)
    );

    isa_vec_bank #(.NVAR(NVAR), .XLEN(XLEN)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(vec_wr_en), .wr_var(vec_wr_var),
        .wr_kind(vec_wr_kind), .wr_data(vec_wr_data), .sel_var(active_idx),
        .trap_req(trap_req), .trap_kind(trap_kind), .trap_vec(trap_vec),
        .trap_vec_valid(trap_vec_valid)
    );

    isa_dec_onehot #(.NVAR(NVAR)) dec_i (
        .active_idx(active_idx), .dec_en(dec_en)
    );
endmodule

// File: rtl/isa_variant_ctl_chk.sv
module isa_variant_ctl_chk #(
    parameter int NVAR = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_wr_en,
    input logic [31:0]     id_rd_data,
    input logic            trap_req,
    input logic            trap_vec_valid,
    input logic [NVAR-1:0] dec_en,
    input logic            stall
);
    // R4: exactly one engine enabled
    a_r4_onehot_en: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec_en) == 1);

    // R5: stall lasts a single cycle
    a_r5_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R5, R3: a stall only follows an identifier write
    a_r5_stall_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(id_wr_en));

    // R5, R9: the active identifier changes only at the end of a stall
    a_r9_id_change_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd_data != $past(id_rd_data)) |-> $past(stall));

    // R8: every trap request yields a valid vector next cycle
    a_r8_trap_valid: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> trap_vec_valid);

    // R8: no vector without a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> !trap_vec_valid);

    // R9: a trap outside a switch leaves the identifier as it was
    a_r9_trap_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !stall) |=> $stable(id_rd_data));
endmodule

bind isa_variant_ctl isa_variant_ctl_chk #(.NVAR(NVAR)) chk_i (
    .clk(clk), .rst_n(rst_n), .id_wr_en(id_wr_en), .id_rd_data(id_rd_data),
    .trap_req(trap_req), .trap_vec_valid(trap_vec_valid), .dec_en(dec_en),
    .stall(stall)
);

// File: tb/isa_variant_ctl_tb_top.sv
`timescale 1ns/1ps
module isa_variant_ctl_tb_top;
    localparam logic [15:0] VEND  = 16'h05A1;
    localparam logic [15:0] ABASE = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_wr_en = 1'b0;
    logic [31:0] id_wr_data = '0;
    logic [31:0] id_rd_data;
    logic        vec_wr_en = 1'b0;
    logic [1:0]  vec_wr_var = '0;
    logic [1:0]  vec_wr_kind = '0;
    logic [31:0] vec_wr_data = '0;
    logic        trap_req = 1'b0;
    logic [1:0]  trap_kind = '0;
    logic [31:0] trap_vec;
    logic        trap_vec_valid;
    logic [3:0]  dec_en;
    logic        stall;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q [$];
    logic [31:0] mvec [4][3];
    int          mact = 0;

    always #2 clk = ~clk;

    isa_variant_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .id_wr_en(id_wr_en), .id_wr_data(id_wr_data),
        .id_rd_data(id_rd_data), .vec_wr_en(vec_wr_en), .vec_wr_var(vec_wr_var),
        .vec_wr_kind(vec_wr_kind), .vec_wr_data(vec_wr_data), .trap_req(trap_req),
        .trap_kind(trap_kind), .trap_vec(trap_vec), .trap_vec_valid(trap_vec_valid),
        .dec_en(dec_en), .stall(stall)
    );

    function automatic logic [31:0] pair(int k);
        return {VEND, ABASE + 16'(k)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected trap vectors
    always @(negedge clk) begin
        if (rst_n && trap_vec_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R8 unexpected vector", trap_vec, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(trap_vec === e, "R8/R10/R11 trap vector", trap_vec, e);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_vec(input int v, input int k, input logic [31:0] d);
        vec_wr_en = 1'b1; vec_wr_var = 2'(v); vec_wr_kind = 2'(k); vec_wr_data = d;
        step();
        vec_wr_en = 1'b0;
        if (k < 3) mvec[v][k] = d;
    endtask

    function automatic logic [31:0] expv(int v, int k);
        return (k < 3) ? mvec[v][k] : 32'h0;
    endfunction

    task automatic trap(input int k);
        exp_q.push_back(expv(mact, k));
        trap_req = 1'b1; trap_kind = 2'(k);
        step();
        trap_req = 1'b0;
    endtask

    task automatic check_active(input string req);
        @(negedge clk);
        chk(id_rd_data === pair(mact), req, id_rd_data, pair(mact));
        chk(dec_en === 4'(1 << mact), "R4 one-hot enables", 32'(dec_en), 32'(1 << mact));
    endtask

    // legal switch: checks stall timing and commit
    task automatic switch_to(input int k);
        id_wr_en = 1'b1; id_wr_data = pair(k);
        step();
        id_wr_en = 1'b0;
        @(negedge clk);
        chk(stall === 1'b1, "R5 stall after write", 32'(stall), 32'h1);
        chk(id_rd_data === pair(mact), "R5 old id during stall", id_rd_data, pair(mact));
        @(posedge clk); #1;
        mact = k;
        @(negedge clk);
        chk(stall === 1'b0, "R5 stall single cycle", 32'(stall), 32'h0);
        check_active("R2 R5 new id after commit");
        @(posedge clk); #1;
    endtask

    task automatic illegal_write(input logic [31:0] d);
        id_wr_en = 1'b1; id_wr_data = d;
        step();
        id_wr_en = 1'b0;
        @(negedge clk);
        chk(stall === 1'b0, "R3 no stall on illegal id", 32'(stall), 32'h0);
        @(posedge clk); #1;
        check_active("R3 id unchanged");
    endtask

    initial begin
        for (int v = 0; v < 4; v++)
            for (int k = 0; k < 3; k++)
                mvec[v][k] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(stall === 1'b0, "R1 reset stall", 32'(stall), 32'h0);
        chk(trap_vec_valid === 1'b0, "R1 reset valid", 32'(trap_vec_valid), 32'h0);
        check_active("R1 reset id");
        @(posedge clk); #1;
        trap(0); trap(2);                         // R1 zero vectors
        // R7 vector writes
        for (int v = 0; v < 4; v++)
            for (int k = 0; k < 3; k++)
                wr_vec(v, k, 32'h8000_0000 + 32'(v * 16'h100 + k * 4'h4));
        wr_vec(0, 3, 32'hDEAD_BEEF);              // R7 kind 3 ignored
        wr_vec(2, 1, 32'h4444_0040);
        trap(0); trap(1); trap(2); trap(3);       // R8, R7
        // R3 illegal identifiers
        illegal_write({16'h1234, ABASE});
        illegal_write(pair(4));
        illegal_write({VEND, ABASE - 16'd1});
        // R5 switch to variant 1
        switch_to(1);
        trap(0); trap(2);
        // R9 trap does not alter id
        check_active("R9 id stable after trap");
        // R10: trap on same edge as write to variant 2
        exp_q.push_back(expv(mact, 1));
        trap_req = 1'b1; trap_kind = 2'd1; id_wr_en = 1'b1; id_wr_data = pair(2);
        step();
        trap_req = 1'b0; id_wr_en = 1'b0;
        // R10: trap during the stall cycle, still old variant
        exp_q.push_back(expv(mact, 0));
        trap_req = 1'b1; trap_kind = 2'd0;
        step();
        trap_req = 1'b0;
        mact = 2;
        check_active("R10 switch committed");
        @(posedge clk); #1;
        trap(1);
        // R6 write during stall ignored
        id_wr_en = 1'b1; id_wr_data = pair(3);
        step();
        id_wr_data = pair(0);
        step();
        id_wr_en = 1'b0;
        mact = 3;
        check_active("R6 write in stall ignored");
        @(posedge clk); #1;
        // R11 vectors survive switches
        switch_to(0);
        trap(0); trap(1); trap(2);
        switch_to(1);
        trap(1);
        switch_to(3);
        trap(2);
        repeat (4) step();
        chk(exp_q.size() == 0, "R8 all traps serviced", 32'(exp_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule